// File: doc/BRIEF.md
# Vertex Attribute Staging with Round-Robin Input Buffer Transfer

This block sits between a host-side attribute fetch path and a set of per-thread input buffers of a vertex processor. The host writes one attribute register at a time, giving the attribute number, a lane count and up to four 32-bit floating-point lanes. Lanes the host leaves out are padded with defaults. Some attributes keep only certain lanes, whatever count the host gives. The padded value lands in one of sixteen staging registers.

Writing the position attribute (attribute 0) marks the vertex as complete. The block then copies the staging set into the next input buffer in round-robin order, one register per cycle. Each buffer has its own dirty flags, so only registers that changed since that buffer was last filled are copied. The position register is always copied, and always last. When the copy ends, a one-cycle fill event names the buffer, and that buffer counts as busy until the consumer releases it. Host writes are held off while a copy runs, and also while the next buffer in turn is still busy. A read port gives the consumer access to any register of any input buffer.

Top module: `attr_rr_xfer`

## Requirements
- R1: After reset `wr_ready` is 1, `fill_valid` is 0, and every input buffer register reads as zero. The staging registers reset to (0,0,0,1.0) and every register counts as changed for every buffer.
- R2: The host value is padded before it is stored. Lane i sits at bits [32*i +: 32], with x in lane 0. Lanes with index at or above `wr_count` become 0, except lane 3, which becomes 1.0 (32'h3F800000). A count of 0 pads all four lanes, and counts above 4 act as 4.
- R3: Attributes 1 and 5 keep only lane 0 from the host, so their result is (v,0,0,1.0). Attributes 2 and 4 keep at most three lanes, so their lane 3 is always 1.0.
- R4: An accepted write to attribute 0 starts a transfer. Once the fill event has occurred, every one of the 16 registers of the filled buffer reads back the current staged values.
- R5: Successive transfers fill buffers 0, 1, 2, 3, 0, and so on, and `fill_idx` names the buffer just filled.
- R6: A transfer copies one register per cycle: each register changed since that buffer's last fill, plus attribute 0. `wr_ready` stays low for exactly that many cycles. Writing a value equal to the staged one does not count as a change.
- R7: Attribute 0 is copied in the last copy cycle. `fill_valid` pulses for exactly one cycle, in the cycle after the last copy.
- R8: A filled buffer stays busy until `rel_valid` names it. While the next round-robin buffer is busy, `wr_ready` is 0. It returns to 1 in the cycle after the release.
- R9: While `wr_valid` is 0, the inputs change neither the staging registers nor the buffers, and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host attribute write request |
| wr_ready | output | 1 | Write accepted on a clock where valid and ready are both 1 |
| wr_attr | input | 4 | Attribute register number |
| wr_count | input | 3 | Number of lanes the host supplies |
| wr_data | input | 128 | Four 32-bit lanes, lane 0 in the low bits |
| fill_valid | output | 1 | One-cycle pulse when a buffer transfer completes |
| fill_idx | output | 2 | Index of the buffer just filled |
| rel_valid | input | 1 | Consumer releases a buffer |
| rel_idx | input | 2 | Index of the released buffer |
| rd_buf | input | 2 | Input buffer selected for reading |
| rd_attr | input | 4 | Register selected for reading |
| rd_data | output | 128 | Combinational read data |

## Verification
A corrupted dirty flag or pending mask changes the number of copy cycles. This shows up at once as `wr_ready` returning a cycle early or late and `fill_valid` moving with it. A skipped register shows up as stale read data on the first readback after that fill. A wrong round-robin pointer or busy flag shows up at the next fill, either as a wrong `fill_idx` or as `wr_ready` staying low (or going high) against the release history. Because ready and fill are compared against a reference model on every clock, each of these faults is reported within the cycle it first becomes visible.

// File: rtl/vab_pkg.sv
package vab_pkg;
  typedef enum logic [0:0] {XF_IDLE = 1'b0, XF_COPY = 1'b1} xfer_state_e;
  localparam logic [31:0] FP_ONE = 32'h3F80_0000;
endpackage

// File: rtl/vab_pad.sv
module vab_pad #(
  parameter int LANE_W   = 32,
  parameter int ATTR_W   = 4,
  parameter int SCALAR_A = 1,
  parameter int SCALAR_B = 5,
  parameter int TRIPLE_A = 2,
  parameter int TRIPLE_B = 4,
  parameter logic [LANE_W-1:0] ONE_VAL = vab_pkg::FP_ONE,
  localparam int QUAD_W  = 4 * LANE_W
) (
  input  logic [ATTR_W-1:0] attr,
  input  logic [2:0]        count,
  input  logic [QUAD_W-1:0] data_in,
  output logic [QUAD_W-1:0] quad_out
);
  logic [2:0] lane_max;
  logic [2:0] lane_eff;

  always_comb begin
    if (attr == ATTR_W'(SCALAR_A) || attr == ATTR_W'(SCALAR_B)) begin
      lane_max = 3'd1;
    end else if (attr == ATTR_W'(TRIPLE_A) || attr == ATTR_W'(TRIPLE_B)) begin
      lane_max = 3'd3;
    end else begin
      lane_max = 3'd4;
    end
    lane_eff = (count < lane_max) ? count : lane_max;
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    localparam logic [LANE_W-1:0] DEF = (l == 3) ? ONE_VAL : '0;
    assign quad_out[l*LANE_W +: LANE_W] =
      (3'(l) < lane_eff) ? data_in[l*LANE_W +: LANE_W] : DEF;
  end
endmodule

// File: rtl/vab_stage.sv
module vab_stage #(
  parameter int NUM_ATTR = 16,
  parameter int NUM_BUF  = 4,
  parameter int LANE_W   = 32,
  parameter logic [LANE_W-1:0] ONE_VAL = vab_pkg::FP_ONE,
  localparam int ATTR_W  = $clog2(NUM_ATTR),
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int QUAD_W  = 4 * LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ATTR_W-1:0]   wr_attr,
  input  logic [QUAD_W-1:0]   wr_quad,
  input  logic                clr_en,
  input  logic [BUF_W-1:0]    clr_buf,
  input  logic [ATTR_W-1:0]   clr_attr,
  input  logic [BUF_W-1:0]    row_buf,
  output logic [NUM_ATTR-1:0] dirty_row,
  input  logic [ATTR_W-1:0]   rd_attr,
  output logic [QUAD_W-1:0]   rd_quad
);
  localparam logic [QUAD_W-1:0] RESET_QUAD = {ONE_VAL, {(3*LANE_W){1'b0}}};

  logic [QUAD_W-1:0]   stage_q [NUM_ATTR];
  logic [NUM_ATTR-1:0] dirty_q [NUM_BUF];
  logic [NUM_ATTR-1:0] dirty_d [NUM_BUF];
  logic                changed;

  assign changed   = wr_en && (wr_quad != stage_q[wr_attr]);
  assign dirty_row = dirty_q[row_buf];
  assign rd_quad   = stage_q[rd_attr];

  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
    logic ld_en;
    assign ld_en = changed && (wr_attr == ATTR_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[a] <= RESET_QUAD;
      end else if (ld_en) begin
        stage_q[a] <= wr_quad;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      dirty_d[b] = dirty_q[b];
      if (changed) begin
        dirty_d[b][wr_attr] = 1'b1;
      end
      if (clr_en && (clr_buf == BUF_W'(b))) begin
        dirty_d[b][clr_attr] = 1'b0;
      end
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_dirty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dirty_q[b] <= '1;
      end else begin
        dirty_q[b] <= dirty_d[b];
      end
    end
  end
endmodule

// File: rtl/vab_xfer_ctrl.sv
module vab_xfer_ctrl #(
  parameter int NUM_ATTR = 16,
  parameter int NUM_BUF  = 4,
  localparam int ATTR_W  = $clog2(NUM_ATTR),
  localparam int BUF_W   = $clog2(NUM_BUF)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [ATTR_W-1:0]   wr_attr,
  input  logic [NUM_ATTR-1:0] dirty_row,
  input  logic                rel_valid,
  input  logic [BUF_W-1:0]    rel_idx,
  output logic                wr_ready,
  output logic [BUF_W-1:0]    ptr,
  output logic                copy_en,
  output logic [ATTR_W-1:0]   copy_attr,
  output logic                fill_valid,
  output logic [BUF_W-1:0]    fill_idx,
  output logic [NUM_BUF-1:0]  busy
);
  import vab_pkg::*;

  xfer_state_e         state_q, state_d;
  logic [BUF_W-1:0]    ptr_q, ptr_d, ptr_nxt;
  logic [NUM_BUF-1:0]  busy_q, busy_d;
  logic [NUM_ATTR-1:0] pend_q, pend_d;
  logic                fill_q, fill_d;
  logic [BUF_W-1:0]    fidx_q, fidx_d;
  logic [ATTR_W-1:0]   sel;
  logic                found;

  // lowest pending register above attribute 0
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int a = NUM_ATTR - 1; a >= 1; a--) begin
      if (pend_q[a]) begin
        sel   = ATTR_W'(a);
        found = 1'b1;
      end
    end
  end

  assign ptr_nxt = (ptr_q == BUF_W'(NUM_BUF - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    busy_d  = busy_q;
    pend_d  = pend_q;
    fill_d  = 1'b0;
    fidx_d  = fidx_q;
    if (rel_valid) begin
      busy_d[rel_idx] = 1'b0;
    end
    case (state_q)
      XF_IDLE: begin
        if (wr_fire && (wr_attr == '0)) begin
          pend_d  = dirty_row | NUM_ATTR'(1);
          state_d = XF_COPY;
        end
      end
      XF_COPY: begin
        pend_d[sel] = 1'b0;
        if (!found) begin
          state_d       = XF_IDLE;
          fill_d        = 1'b1;
          fidx_d        = ptr_q;
          busy_d[ptr_q] = 1'b1;
          ptr_d         = ptr_nxt;
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      ptr_q   <= '0;
      busy_q  <= '0;
      pend_q  <= '0;
      fill_q  <= 1'b0;
      fidx_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      fill_q  <= fill_d;
      fidx_q  <= fidx_d;
    end
  end

  assign wr_ready   = (state_q == XF_IDLE) && !busy_q[ptr_q];
  assign ptr        = ptr_q;
  assign copy_en    = (state_q == XF_COPY);
  assign copy_attr  = sel;
  assign fill_valid = fill_q;
  assign fill_idx   = fidx_q;
  assign busy       = busy_q;
endmodule

// File: rtl/vab_ibuf_bank.sv
module vab_ibuf_bank #(
  parameter int NUM_ATTR = 16,
  parameter int NUM_BUF  = 4,
  parameter int LANE_W   = 32,
  localparam int ATTR_W  = $clog2(NUM_ATTR),
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int QUAD_W  = 4 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BUF_W-1:0]  w_buf,
  input  logic [ATTR_W-1:0] w_attr,
  input  logic [QUAD_W-1:0] w_quad,
  input  logic [BUF_W-1:0]  r_buf,
  input  logic [ATTR_W-1:0] r_attr,
  output logic [QUAD_W-1:0] r_quad
);
  logic [QUAD_W-1:0] mem_q [NUM_BUF][NUM_ATTR];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    for (genvar a = 0; a < NUM_ATTR; a++) begin : g_reg
      logic hit;
      assign hit = we && (w_buf == BUF_W'(b)) && (w_attr == ATTR_W'(a));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[b][a] <= '0;
        end else if (hit) begin
          mem_q[b][a] <= w_quad;
        end
      end
    end
  end

  assign r_quad = mem_q[r_buf][r_attr];
endmodule

// File: rtl/attr_rr_xfer.sv
module attr_rr_xfer #(
  parameter int NUM_ATTR = 16,
  parameter int NUM_BUF  = 4,
  parameter int LANE_W   = 32,
  localparam int ATTR_W  = $clog2(NUM_ATTR),
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int QUAD_W  = 4 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [2:0]        wr_count,
  input  logic [QUAD_W-1:0] wr_data,
  output logic              fill_valid,
  output logic [BUF_W-1:0]  fill_idx,
  input  logic              rel_valid,
  input  logic [BUF_W-1:0]  rel_idx,
  input  logic [BUF_W-1:0]  rd_buf,
  input  logic [ATTR_W-1:0] rd_attr,
  output logic [QUAD_W-1:0] rd_data
);
  logic                wr_fire;
  logic [QUAD_W-1:0]   pad_quad;
  logic [QUAD_W-1:0]   stage_quad;
  logic [NUM_ATTR-1:0] dirty_row;
  logic [BUF_W-1:0]    ptr;
  logic                copy_en;
  logic [ATTR_W-1:0]   copy_attr;
  logic [NUM_BUF-1:0]  busy;

  assign wr_fire = wr_valid && wr_ready;

  vab_pad #(.LANE_W(LANE_W), .ATTR_W(ATTR_W)) u_pad (
    .attr     (wr_attr),
    .count    (wr_count),
    .data_in  (wr_data),
    .quad_out (pad_quad)
  );

  vab_stage #(.NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire),
    .wr_attr   (wr_attr),
    .wr_quad   (pad_quad),
    .clr_en    (copy_en),
    .clr_buf   (ptr),
    .clr_attr  (copy_attr),
    .row_buf   (ptr),
    .dirty_row (dirty_row),
    .rd_attr   (copy_attr),
    .rd_quad   (stage_quad)
  );

  vab_xfer_ctrl #(.NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_attr    (wr_attr),
    .dirty_row  (dirty_row),
    .rel_valid  (rel_valid),
    .rel_idx    (rel_idx),
    .wr_ready   (wr_ready),
    .ptr        (ptr),
    .copy_en    (copy_en),
    .copy_attr  (copy_attr),
    .fill_valid (fill_valid),
    .fill_idx   (fill_idx),
    .busy       (busy)
  );

  vab_ibuf_bank #(.NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (copy_en),
    .w_buf  (ptr),
    .w_attr (copy_attr),
    .w_quad (stage_quad),
    .r_buf  (rd_buf),
    .r_attr (rd_attr),
    .r_quad (rd_data)
  );
endmodule

// File: rtl/attr_rr_xfer_chk.sv
module attr_rr_xfer_chk #(
  parameter int NUM_ATTR = 16,
  parameter int NUM_BUF  = 4,
  localparam int ATTR_W  = $clog2(NUM_ATTR),
  localparam int BUF_W   = $clog2(NUM_BUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ready,
  input logic               copy_en,
  input logic [ATTR_W-1:0]  copy_attr,
  input logic               fill_valid,
  input logic [BUF_W-1:0]   fill_idx,
  input logic [NUM_BUF-1:0] busy
);
  logic [BUF_W-1:0] exp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_idx <= '0;
    end else if (fill_valid) begin
      exp_idx <= (exp_idx == BUF_W'(NUM_BUF - 1)) ? '0 : exp_idx + 1'b1;
    end
  end

  assert_no_write_in_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |-> !wr_ready);

  assert_pos_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && copy_attr == '0) |=> (!copy_en && fill_valid));

  assert_fill_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);

  assert_rr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_idx == exp_idx));

  assert_filled_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> busy[fill_idx]);
endmodule

bind attr_rr_xfer attr_rr_xfer_chk #(.NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .copy_en    (copy_en),
  .copy_attr  (copy_attr),
  .fill_valid (fill_valid),
  .fill_idx   (fill_idx),
  .busy       (busy)
);

// File: tb/attr_rr_xfer_tb.sv
module attr_rr_xfer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONE = 32'h3F80_0000;

  logic         clk;
  logic         rst_n;
  logic         wr_valid;
  logic         wr_ready;
  logic [3:0]   wr_attr;
  logic [2:0]   wr_count;
  logic [127:0] wr_data;
  logic         fill_valid;
  logic [1:0]   fill_idx;
  logic         rel_valid;
  logic [1:0]   rel_idx;
  logic [1:0]   rd_buf;
  logic [3:0]   rd_attr;
  logic [127:0] rd_data;

  attr_rr_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_attr(wr_attr), .wr_count(wr_count), .wr_data(wr_data),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .rel_valid(rel_valid),
    .rel_idx(rel_idx), .rd_buf(rd_buf), .rd_attr(rd_attr), .rd_data(rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int lowcnt  = 0;
  int n_fills = 0;

  // reference model
  logic [127:0] m_stage [16];
  logic [127:0] m_ib    [4][16];
  bit           m_dirty [4][16];
  bit           m_busy  [4];
  int           m_ptr, m_cnt, m_cur, m_fill_idx;
  bit           m_fill;

  function automatic logic [127:0] exp_pad(int a, int cnt, logic [127:0] d);
    int mx;
    int n;
    logic [127:0] q;
    mx = (a == 1 || a == 5) ? 1 : ((a == 2 || a == 4) ? 3 : 4);
    n  = (cnt < mx) ? cnt : mx;
    for (int i = 0; i < 4; i++) begin
      q[i*32 +: 32] = (i < n) ? d[i*32 +: 32] : ((i == 3) ? ONE : 32'h0);
    end
    return q;
  endfunction

  function automatic bit m_ready();
    return (m_cnt == 0) && !m_busy[m_ptr];
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        m_busy[b] = 0;
        for (int a = 0; a < 16; a++) begin
          m_ib[b][a]    = '0;
          m_dirty[b][a] = 1;
        end
      end
      for (int a = 0; a < 16; a++) m_stage[a] = {ONE, 96'h0};
      m_ptr = 0; m_cnt = 0; m_cur = 0; m_fill = 0; m_fill_idx = 0;
    end else begin
      bit rdy;
      rdy    = m_ready();
      m_fill = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_fill     = 1;
          m_fill_idx = m_cur;
          m_busy[m_cur] = 1;
          for (int a = 0; a < 16; a++) begin
            m_ib[m_cur][a]    = m_stage[a];
            m_dirty[m_cur][a] = 0;
          end
          m_ptr = (m_ptr + 1) % 4;
        end
      end else if (wr_valid && rdy) begin
        logic [127:0] q;
        int a;
        a = int'(wr_attr);
        q = exp_pad(a, int'(wr_count), wr_data);
        if (q != m_stage[a]) begin
          m_stage[a] = q;
          for (int b = 0; b < 4; b++) m_dirty[b][a] = 1;
        end
        if (a == 0) begin
          m_cur = m_ptr;
          m_cnt = 1;
          for (int k = 1; k < 16; k++) if (m_dirty[m_ptr][k]) m_cnt++;
        end
      end
      if (rel_valid) m_busy[rel_idx] = 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_ready == m_ready(), (m_cnt > 0) ? "R6" : "R8", "wr_ready",
          128'(wr_ready), 128'(m_ready()));
      chk(fill_valid == m_fill, "R7", "fill_valid", 128'(fill_valid), 128'(m_fill));
      if (fill_valid && m_fill)
        chk(fill_idx == 2'(m_fill_idx), "R5", "fill_idx", 128'(fill_idx), 128'(m_fill_idx));
      if (!wr_ready) lowcnt++;
      if (fill_valid) n_fills++;
    end
  end

  task automatic host_write(int a, int cnt, logic [127:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_attr = 4'(a); wr_count = 3'(cnt); wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_cnt != 0 || m_fill) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_buf(int b);
    @(negedge clk);
    rel_valid = 1'b1; rel_idx = 2'(b);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic check_buf(int b, string tag);
    for (int a = 0; a < 16; a++) begin
      rd_buf = 2'(b); rd_attr = 4'(a);
      #1;
      if (a == 1 || a == 2 || a == 4 || a == 5)
        chk(rd_data == m_ib[b][a], "R3", $sformatf("buf%0d attr%0d", b, a), rd_data, m_ib[b][a]);
      else
        chk(rd_data == m_ib[b][a], tag, $sformatf("buf%0d attr%0d", b, a), rd_data, m_ib[b][a]);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int fills_before;
    logic [127:0] hold;
    rst_n = 1'b0; wr_valid = 1'b0; wr_attr = '0; wr_count = '0; wr_data = '0;
    rel_valid = 1'b0; rel_idx = '0; rd_buf = '0; rd_attr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", 128'(wr_ready), 128'(1));
    chk(fill_valid == 1'b0, "R1", "fill_valid after reset", 128'(fill_valid), 128'(0));
    rd_buf = 2'd2; rd_attr = 4'd9; #1;
    chk(rd_data == '0, "R1", "buffer reg after reset", rd_data, 128'h0);

    // R2/R3: padding under several counts and attributes
    host_write(2, 4, {32'hA4, 32'hA3, 32'hA2, 32'hA1});
    host_write(1, 3, {32'hB4, 32'hB3, 32'hB2, 32'hB1});
    host_write(3, 2, {32'hC4, 32'hC3, 32'hC2, 32'hC1});
    host_write(5, 4, {32'hD4, 32'hD3, 32'hD2, 32'hD1});
    host_write(4, 4, {32'hE4, 32'hE3, 32'hE2, 32'hE1});
    host_write(8, 0, {32'hF4, 32'hF3, 32'hF2, 32'hF1});
    host_write(9, 7, {32'h94, 32'h93, 32'h92, 32'h91});
    // R4: position write triggers the transfer into buffer 0
    host_write(0, 4, {32'h04, 32'h03, 32'h02, 32'h01});
    wait_idle();
    check_buf(0, "R2");

    // R5: round robin through buffers 1..3
    host_write(3, 4, {32'h34, 32'h33, 32'h32, 32'h31});
    host_write(0, 3, {32'h14, 32'h13, 32'h12, 32'h11});
    wait_idle();
    check_buf(1, "R4");
    host_write(0, 4, {32'h24, 32'h23, 32'h22, 32'h21});
    wait_idle();
    host_write(0, 2, {32'h44, 32'h43, 32'h42, 32'h41});
    wait_idle();
    check_buf(3, "R4");

    // R8: all buffers busy, next in turn (0) blocks the host
    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b0, "R8", "ready while next buffer busy", 128'(wr_ready), 128'(0));
    release_buf(0);
    chk(wr_ready == 1'b1, "R8", "ready after release", 128'(wr_ready), 128'(1));
    release_buf(1); release_buf(2); release_buf(3);

    // R6: unchanged write does not count; only attr3, attr9 and attr0 copied
    host_write(7, 0, 128'h0);
    host_write(9, 4, {32'h9D, 32'h9C, 32'h9B, 32'h9A});
    @(negedge clk);
    lowcnt = 0;
    host_write(0, 4, {32'h54, 32'h53, 32'h52, 32'h51});
    wait_idle();
    chk(lowcnt == 3, "R6", "copy cycles for dirty set", 128'(lowcnt), 128'(3));
    check_buf(0, "R4");
    release_buf(0);

    // R9: inputs without wr_valid change nothing
    fills_before = n_fills;
    rd_buf = 2'd1; rd_attr = 4'd0; #1;
    hold = rd_data;
    @(negedge clk);
    wr_valid = 1'b0; wr_attr = 4'd0; wr_count = 3'd4; wr_data = {4{32'hDEAD_BEEF}};
    repeat (6) @(negedge clk);
    chk(n_fills == fills_before, "R9", "fills without wr_valid", 128'(n_fills), 128'(fills_before));
    rd_buf = 2'd1; rd_attr = 4'd0; #1;
    chk(rd_data == hold, "R9", "buffer unchanged without wr_valid", rd_data, hold);
    // next real fill goes to buffer 1 and must not carry the ignored data
    host_write(6, 1, {32'h0, 32'h0, 32'h0, 32'h66});
    host_write(0, 4, {32'h74, 32'h73, 32'h72, 32'h71});
    wait_idle();
    check_buf(1, "R9");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule